// File: doc/BRIEF.md
# Message-Signalled Interrupt File

This block is the interrupt file for a single hart. Devices post message-signalled interrupts as 32-bit writes into a small window. Each write carries an identity number, and the block sets the pending bit for that identity. The window has two word offsets. One takes the identity from the low half of the data word, for little-endian senders. The other takes it from the high half, for big-endian senders.

Software sees the file through an indirect port: it places a select code on the port and then reads or writes one 32-bit data word. That word can be the delivery switch, the priority threshold, one word of pending bits or one word of enable bits. A separate read port shows the best interrupt that is both pending and enabled. Priority is the identity number, and a lower number wins. A one-cycle claim strobe clears the pending bit of the identity being shown. A single request line to the hart is high while delivery is on and an interrupt is selectable.

Top module: `msi_intr_file`

## Requirements
- R1: A write at byte offset 0x000 takes identity k from data bits 15:0 and sets pending bit k. That bit sits in pending word (k-1)/32 at bit (k-1)%32. Pending word n reads back at select code 0x80+n from the cycle after the write.
- R2: A write at byte offset 0x004 takes the identity from data bits 31:16 and ignores bits 15:0.
- R3: A message write is ignored if its identity is 0, if its identity exceeds MAX_ID (default 63), or if it lands at any offset other than 0x000 or 0x004.
- R4: When at least one identity is both pending and enabled, the top value carries the lowest such identity in bits 31:16 and again in bits 10:0. All its other bits are zero. It reads all zeros when no identity is selectable.
- R5: An identity is selectable only when its enable bit is set. Enable word n sits at select code 0xC0+n, with the same bit mapping as R1.
- R6: The threshold register is at select code 0x72 and keeps the low 11 bits of a write. A nonzero threshold T limits selection to identities below T. A threshold of zero masks nothing.
- R7: A claim strobe clears the pending bit of the identity shown in the top value in that cycle. A claim has no effect while the top value is zero.
- R8: If a message write sets the identity being claimed in the same cycle, the set wins and the bit stays pending.
- R9: The delivery register is at select code 0x70. Writing 0 turns delivery off and writing 1 turns it on. Any other value, including 0x40000000, leaves it unchanged. It reads back as 0 or 1.
- R10: The request output is high exactly when delivery is on and the top value is nonzero. It follows any register change on the cycle after that change.
- R11: Pending and enable words are readable and writable. Bits for identities above MAX_ID always read zero.
- R12: Select codes outside 0x70, 0x72 and the implemented pending and enable words read zero and ignore writes.
- R13: A synchronous active-low reset clears all pending bits, enable bits, the threshold and delivery, so the top value and the request read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msi_wr_en | input | 1 | Message write strobe |
| msi_addr | input | 12 | Byte offset of the message write within the window |
| msi_wdata | input | 32 | Message write data |
| cfg_sel | input | 8 | Indirect register select code |
| cfg_wr_en | input | 1 | Indirect write strobe |
| cfg_wdata | input | 32 | Indirect write data |
| cfg_rdata | output | 32 | Indirect read data for the current select code |
| top_claim | input | 1 | Claim strobe for the identity in top_value |
| top_value | output | 32 | Best selectable identity and its priority |
| irq | output | 1 | Interrupt request to the hart |

## Verification
All state is registered and the selection logic is purely combinational, so a wrong pending, enable or threshold bit shows at top_value and irq on the very next cycle. It shows there only if that bit is the best candidate. The bench therefore builds orderings in which the faulty bit would win: a lower identity hidden by its enable bit, an identity exactly at the threshold, and a claim that meets a fresh set of the same identity. Hidden state is read back through the indirect port. This catches a wrong word and bit mapping, or an unmasked bit above MAX_ID, even when the top value does not change.

// File: rtl/msi_pkg.sv
// Package: msi_pkg
// Shared constants for the message-signalled interrupt file: indirect select
// codes, message window offsets and the identity width. It also has a helper
// that packs an identity into the top-value word.
// Assumes identities never exceed 2047, so 11 bits hold any of them.
package msi_pkg;

    localparam int          ID_W          = 11;
    localparam int          MAX_LEGAL_ID  = 2047;
    localparam logic [7:0]  SEL_DELIV     = 8'h70;
    localparam logic [7:0]  SEL_THRESH    = 8'h72;
    localparam logic [7:0]  SEL_PEND_BASE = 8'h80;
    localparam logic [7:0]  SEL_ENAB_BASE = 8'hC0;
    localparam logic [11:0] OFF_LITTLE    = 12'h000;
    localparam logic [11:0] OFF_BIG       = 12'h004;

    // Identity in bits 31:16, the same identity as priority in bits 10:0.
    function automatic logic [31:0] pack_top(input logic [ID_W-1:0] id);
        return {5'b0, id, 5'b0, id};
    endfunction

endpackage

// File: rtl/msi_decode.sv
// Module: msi_decode
// Turns a message write into a pending-bit set request. Offset 0x000 takes the
// identity from data bits 15:0 and offset 0x004 from bits 31:16. Identity 0,
// identities above MAX_ID and all other offsets produce no request.
// Assumes MAX_ID lies between 1 and 2047. Purely combinational.
module msi_decode
    import msi_pkg::*;
#(
    parameter int MAX_ID = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [11:0]      addr,
    input  logic [31:0]      wdata,
    output logic             set_valid,
    output logic [ID_W-1:0]  set_id
);

    logic [15:0] raw_id;
    logic        offset_hit;

    // Pick the half-word that holds the identity and qualify the request.
    always_comb begin
        raw_id     = (addr == OFF_BIG) ? wdata[31:16] : wdata[15:0];
        offset_hit = wr_en && ((addr == OFF_LITTLE) || (addr == OFF_BIG));
        set_valid  = offset_hit && (raw_id != 16'd0) && (raw_id <= 16'(MAX_ID));
        set_id     = raw_id[ID_W-1:0];
    end

    // R3
    bad_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr != OFF_LITTLE) && (addr != OFF_BIG)) |-> !set_valid);

    // R3
    id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |-> ((set_id != '0) && (32'(set_id) <= MAX_ID)));

endmodule

// File: rtl/msi_select.sv
// Module: msi_select
// Finds the lowest identity that is pending, enabled and below the threshold.
// A zero threshold masks nothing. Bit i of the vectors stands for identity i+1.
// Assumes bits for identities above MAX_ID are already zero in pend.
// Purely combinational.
module msi_select
    import msi_pkg::*;
#(
    parameter int NBITS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] pend,
    input  logic [NBITS-1:0] enab,
    input  logic [ID_W-1:0]  thresh,
    output logic             found,
    output logic [ID_W-1:0]  top_id
);

    logic [NBITS-1:0] elig;
    logic [NBITS-1:0] top_mask;

    // Per-identity eligibility: pending, enabled and under the threshold.
    for (genvar i = 0; i < NBITS; i++) begin : g_elig
        assign elig[i] = pend[i] & enab[i] &
                         ((thresh == '0) || ((ID_W+1)'(i + 1) < {1'b0, thresh}));
    end

    // Priority scan: the lowest eligible index wins.
    always_comb begin
        found  = 1'b0;
        top_id = '0;
        for (int i = NBITS - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found  = 1'b1;
                top_id = ID_W'(i + 1);
            end
        end
    end

    // One-hot mask of the chosen identity, used only by the checks below.
    assign top_mask = found ? (NBITS'(1) << (top_id - 1'b1)) : '0;

    // R5
    winner_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> ((pend & enab & top_mask) != '0));

    // R6
    under_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (found && (thresh != '0)) |-> (top_id < thresh));

    // R4
    empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !found |-> (top_id == '0));

endmodule

// File: rtl/msi_ireg_file.sv
// Module: msi_ireg_file
// Holds the file state: pending and enable bits, the threshold and the
// delivery switch. Serves the indirect select/data port and applies message
// sets and claims. Within one cycle an indirect word write goes first, then
// the claim clear, then the message set, so a set always survives.
// Assumes NUM_WORDS <= 64, so the word index is select bits 5:0.
module msi_ireg_file
    import msi_pkg::*;
#(
    parameter int MAX_ID    = 63,
    parameter int NUM_WORDS = 2,
    localparam int NBITS    = NUM_WORDS * 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       sel,
    input  logic             wr_en,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic             set_valid,
    input  logic [ID_W-1:0]  set_id,
    input  logic             claim_valid,
    input  logic [ID_W-1:0]  claim_id,
    output logic [NBITS-1:0] pend,
    output logic [NBITS-1:0] enab,
    output logic [ID_W-1:0]  thresh,
    output logic             deliv
);

    logic [NBITS-1:0] valid_mask;
    logic [NBITS-1:0] set_mask;
    logic [NBITS-1:0] claim_mask;
    logic [NBITS-1:0] pend_n;
    logic [NBITS-1:0] enab_n;
    logic [ID_W-1:0]  thresh_n;
    logic             deliv_n;
    logic             hit_pend;
    logic             hit_enab;
    logic             hit_any;
    logic [5:0]       word_idx;

    // Implemented bits: identities 1 to MAX_ID.
    for (genvar i = 0; i < NBITS; i++) begin : g_mask
        assign valid_mask[i] = (i < MAX_ID);
    end

    // Decode the select code into register hits.
    always_comb begin
        word_idx = sel[5:0];
        hit_pend = (sel >= SEL_PEND_BASE) &&
                   ({1'b0, sel} < 9'(int'(SEL_PEND_BASE) + NUM_WORDS));
        hit_enab = (sel >= SEL_ENAB_BASE) &&
                   ({1'b0, sel} < 9'(int'(SEL_ENAB_BASE) + NUM_WORDS));
        hit_any  = hit_pend || hit_enab || (sel == SEL_DELIV) || (sel == SEL_THRESH);
    end

    // One-hot masks for the message set and the claim.
    assign set_mask   = set_valid   ? (NBITS'(1) << (set_id   - 1'b1)) : '0;
    assign claim_mask = claim_valid ? (NBITS'(1) << (claim_id - 1'b1)) : '0;

    // Next-state logic: indirect write, then claim, then message set.
    always_comb begin
        pend_n   = pend;
        enab_n   = enab;
        thresh_n = thresh;
        deliv_n  = deliv;
        if (wr_en) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (hit_pend && (int'(word_idx) == w)) pend_n[w*32 +: 32] = wdata;
                if (hit_enab && (int'(word_idx) == w)) enab_n[w*32 +: 32] = wdata;
            end
            if (sel == SEL_THRESH) thresh_n = wdata[ID_W-1:0];
            if (sel == SEL_DELIV) begin
                if (wdata == 32'd0)      deliv_n = 1'b0;
                else if (wdata == 32'd1) deliv_n = 1'b1;
            end
        end
        pend_n = ((pend_n & ~claim_mask) | set_mask) & valid_mask;
        enab_n = enab_n & valid_mask;
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= '0;
            enab   <= '0;
            thresh <= '0;
            deliv  <= 1'b0;
        end else begin
            pend   <= pend_n;
            enab   <= enab_n;
            thresh <= thresh_n;
            deliv  <= deliv_n;
        end
    end

    // Indirect read mux; unimplemented codes read zero.
    always_comb begin
        rdata = '0;
        if (sel == SEL_DELIV)  rdata = {31'b0, deliv};
        if (sel == SEL_THRESH) rdata = {{(32-ID_W){1'b0}}, thresh};
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (hit_pend && (int'(word_idx) == w)) rdata = pend[w*32 +: 32];
            if (hit_enab && (int'(word_idx) == w)) rdata = enab[w*32 +: 32];
        end
    end

    // R7
    claim_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_valid && ((set_mask & claim_mask) == '0) && !(wr_en && hit_pend))
        |=> ((pend & $past(claim_mask)) == '0));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |=> ((pend & $past(set_mask)) != '0));

    // R9
    deliv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == SEL_DELIV) && (wdata > 32'd1)) |=> (deliv == $past(deliv)));

    // R12
    unimpl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit_any && !set_valid && !claim_valid)
        |=> ($stable(pend) && $stable(enab) && $stable(thresh) && $stable(deliv)));

endmodule

// File: rtl/msi_intr_file.sv
// Module: msi_intr_file
// Top of the per-hart message-signalled interrupt file. Ties together the
// message decoder, the register state and the priority selector. Drives the
// top value and the request line from registered state, so every change is
// visible on the cycle after it is written.
// Assumes 1 <= MAX_ID <= 2047.
module msi_intr_file
    import msi_pkg::*;
#(
    parameter int MAX_ID = 63
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        msi_wr_en,
    input  logic [11:0] msi_addr,
    input  logic [31:0] msi_wdata,
    input  logic [7:0]  cfg_sel,
    input  logic        cfg_wr_en,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        top_claim,
    output logic [31:0] top_value,
    output logic        irq
);

    localparam int NUM_WORDS = (MAX_ID + 31) / 32;
    localparam int NBITS     = NUM_WORDS * 32;

    logic             set_valid;
    logic [ID_W-1:0]  set_id;
    logic [NBITS-1:0] pend;
    logic [NBITS-1:0] enab;
    logic [ID_W-1:0]  thresh;
    logic             deliv;
    logic             found;
    logic [ID_W-1:0]  top_id;
    logic             claim_valid;

    msi_decode #(.MAX_ID(MAX_ID)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (msi_wr_en),
        .addr      (msi_addr),
        .wdata     (msi_wdata),
        .set_valid (set_valid),
        .set_id    (set_id)
    );

    msi_ireg_file #(.MAX_ID(MAX_ID), .NUM_WORDS(NUM_WORDS)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (cfg_sel),
        .wr_en       (cfg_wr_en),
        .wdata       (cfg_wdata),
        .rdata       (cfg_rdata),
        .set_valid   (set_valid),
        .set_id      (set_id),
        .claim_valid (claim_valid),
        .claim_id    (top_id),
        .pend        (pend),
        .enab        (enab),
        .thresh      (thresh),
        .deliv       (deliv)
    );

    msi_select #(.NBITS(NBITS)) u_select (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend   (pend),
        .enab   (enab),
        .thresh (thresh),
        .found  (found),
        .top_id (top_id)
    );

    // Outputs: claim only counts with a live winner; request needs delivery.
    always_comb begin
        claim_valid = top_claim && found;
        top_value   = found ? pack_top(top_id) : 32'd0;
        irq         = deliv && found;
    end

    // R10
    irq_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (top_value != 32'd0));

    // R4
    top_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (top_value[31:16] == {5'b0, top_value[10:0]}) && (top_value[15:11] == 5'b0));

endmodule

// File: tb/msi_intr_file_bench.sv
module msi_intr_file_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        msi_wr_en;
    logic [11:0] msi_addr;
    logic [31:0] msi_wdata;
    logic [7:0]  cfg_sel;
    logic        cfg_wr_en;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        top_claim;
    logic [31:0] top_value;
    logic        irq;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    msi_intr_file #(.MAX_ID(63)) u_msi_intr_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .msi_wr_en (msi_wr_en),
        .msi_addr  (msi_addr),
        .msi_wdata (msi_wdata),
        .cfg_sel   (cfg_sel),
        .cfg_wr_en (cfg_wr_en),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .top_claim (top_claim),
        .top_value (top_value),
        .irq       (irq)
    );

    // Stimulus table: {op, data, expected top identity after the op}.
    // op 0 = message at offset 0x000, 1 = message at offset 0x004, 2 = claim.
    localparam logic [49:0] VEC [16] = '{
        {2'd0, 32'h0000_0005, 16'd5},   // R1
        {2'd1, 32'h0003_0000, 16'd3},   // R2
        {2'd0, 32'h0000_0000, 16'd3},   // R3 identity 0
        {2'd0, 32'h0000_0040, 16'd3},   // R3 identity 64
        {2'd1, 32'h0000_0002, 16'd3},   // R2 low half ignored
        {2'd0, 32'hABCD_0028, 16'd3},   // R1 identity 40
        {2'd2, 32'h0,         16'd5},   // R7
        {2'd2, 32'h0,         16'd40},
        {2'd1, 32'h003F_1234, 16'd40},  // identity 63
        {2'd2, 32'h0,         16'd63},
        {2'd2, 32'h0,         16'd0},
        {2'd2, 32'h0,         16'd0},   // claim with nothing selectable
        {2'd0, 32'h0000_003F, 16'd63},
        {2'd0, 32'h0000_0001, 16'd1},   // R4 lowest wins
        {2'd2, 32'h0,         16'd63},
        {2'd2, 32'h0,         16'd0}
    };

    function automatic logic [31:0] topw(input int id);
        return (id == 0) ? 32'd0 : {16'(id), 5'b0, 11'(id)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        msi_wr_en = 1'b0;
        cfg_wr_en = 1'b0;
        top_claim = 1'b0;
    endtask

    task automatic msi(input logic [11:0] a, input logic [31:0] d);
        msi_wr_en = 1'b1;
        msi_addr  = a;
        msi_wdata = d;
        step();
    endtask

    task automatic cfg_wr(input logic [7:0] s, input logic [31:0] d);
        cfg_wr_en = 1'b1;
        cfg_sel   = s;
        cfg_wdata = d;
        step();
    endtask

    task automatic cfg_rd(input logic [7:0] s, output logic [31:0] d);
        cfg_sel = s;
        #1;
        d = cfg_rdata;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        rst_n = 1'b0; msi_wr_en = 1'b0; msi_addr = '0; msi_wdata = '0;
        cfg_sel = '0; cfg_wr_en = 1'b0; cfg_wdata = '0; top_claim = 1'b0;
        repeat (3) step();

        // R13 reset state
        chk("R13 top", top_value, 32'd0);
        chk("R13 irq", {31'b0, irq}, 32'd0);
        cfg_rd(8'h70, rd); chk("R13 deliv", rd, 32'd0);
        cfg_rd(8'hC0, rd); chk("R13 enab", rd, 32'd0);
        rst_n = 1'b1;
        step();

        // Enable everything, turn delivery on.
        cfg_wr(8'hC0, 32'hFFFF_FFFF);
        cfg_wr(8'hC1, 32'hFFFF_FFFF);
        cfg_rd(8'hC1, rd); chk("R11 enab upper bits", rd, 32'h7FFF_FFFF);
        cfg_wr(8'h70, 32'd1);

        // Table walk: R1 R2 R3 R4 R7 R10
        for (int i = 0; i < 16; i++) begin
            logic [1:0]  op;
            logic [31:0] dat;
            logic [15:0] exp_id;
            op     = VEC[i][49:48];
            dat    = VEC[i][47:16];
            exp_id = VEC[i][15:0];
            if (op == 2'd2) begin
                top_claim = 1'b1;
                step();
            end else begin
                msi((op == 2'd1) ? 12'h004 : 12'h000, dat);
            end
            chk("R4 table top", top_value, topw(int'(exp_id)));
            chk("R10 table irq", {31'b0, irq}, {31'b0, exp_id != 16'd0});
        end

        // R1 word/bit mapping
        msi(12'h000, 32'd40);
        cfg_rd(8'h81, rd); chk("R1 id40 word1 bit7", rd, 32'h0000_0080);
        msi(12'h004, 32'h0021_0000);
        cfg_rd(8'h81, rd); chk("R2 id33 word1 bit0", rd, 32'h0000_0081);
        msi(12'h000, 32'd32);
        cfg_rd(8'h80, rd); chk("R1 id32 word0 bit31", rd, 32'h8000_0000);
        chk("R4 top 32", top_value, topw(32));

        // R5 enable masking
        cfg_wr(8'hC0, 32'd0);
        chk("R5 disabled word0", top_value, topw(33));
        cfg_wr(8'hC0, 32'hFFFF_FFFF);
        chk("R5 re-enabled", top_value, topw(32));

        // R6 threshold
        cfg_wr(8'h72, 32'd32);
        chk("R6 thresh equal masks", top_value, 32'd0);
        chk("R10 irq masked", {31'b0, irq}, 32'd0);
        cfg_wr(8'h72, 32'd33);
        chk("R6 thresh above", top_value, topw(32));
        cfg_wr(8'h72, 32'hFFFF_FFFF);
        cfg_rd(8'h72, rd); chk("R6 thresh width", rd, 32'h0000_07FF);
        cfg_wr(8'h72, 32'd0);
        chk("R6 thresh zero", top_value, topw(32));

        // R9 / R10 delivery
        cfg_wr(8'h70, 32'd0);
        chk("R10 irq off", {31'b0, irq}, 32'd0);
        chk("R10 top kept", top_value, topw(32));
        cfg_wr(8'h70, 32'h4000_0000);
        cfg_rd(8'h70, rd); chk("R9 unsupported value", rd, 32'd0);
        cfg_wr(8'h70, 32'd1);
        chk("R10 irq on", {31'b0, irq}, 32'd1);
        cfg_wr(8'h70, 32'd2);
        cfg_rd(8'h70, rd); chk("R9 value 2 ignored", rd, 32'd1);

        // R8 claim and set of the same identity
        top_claim = 1'b1;
        msi(12'h000, 32'd32);
        chk("R8 set wins", top_value, topw(32));
        top_claim = 1'b1;
        msi(12'h000, 32'd50);
        chk("R7 claim with other set", top_value, topw(33));
        cfg_rd(8'h81, rd); chk("R1 id50 word1", rd, 32'h0002_0081);

        // R3 other offset
        msi(12'h008, 32'd2);
        chk("R3 offset 8 ignored", top_value, topw(33));

        // R12 unimplemented codes
        cfg_wr(8'h71, 32'hFFFF_FFFF);
        cfg_wr(8'h82, 32'hFFFF_FFFF);
        cfg_wr(8'hC2, 32'hFFFF_FFFF);
        cfg_wr(8'h00, 32'hFFFF_FFFF);
        cfg_rd(8'h71, rd); chk("R12 read 0x71", rd, 32'd0);
        cfg_rd(8'h82, rd); chk("R12 read 0x82", rd, 32'd0);
        cfg_rd(8'hC2, rd); chk("R12 read 0xC2", rd, 32'd0);
        cfg_rd(8'h80, rd); chk("R12 pend0 intact", rd, 32'd0);
        cfg_rd(8'h81, rd); chk("R12 pend1 intact", rd, 32'h0002_0081);
        cfg_rd(8'h72, rd); chk("R12 thresh intact", rd, 32'd0);
        cfg_rd(8'h70, rd); chk("R12 deliv intact", rd, 32'd1);
        chk("R12 top intact", top_value, topw(33));

        // R11 pending word write with unimplemented bit
        cfg_wr(8'h81, 32'hFFFF_FFFF);
        cfg_rd(8'h81, rd); chk("R11 pend upper bits", rd, 32'h7FFF_FFFF);

        // R13 reset from a loaded state
        rst_n = 1'b0;
        step();
        chk("R13 top after reset", top_value, 32'd0);
        chk("R13 irq after reset", {31'b0, irq}, 32'd0);
        cfg_rd(8'h81, rd); chk("R13 pend cleared", rd, 32'd0);
        cfg_rd(8'hC1, rd); chk("R13 enab cleared", rd, 32'd0);
        rst_n = 1'b1;
        step();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule